// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block gathers the interrupt conditions of a UART and turns them into one prioritized identification code plus a single interrupt line. Six conditions feed it: a receive line-status error, receive data reaching the trigger level, a receive timeout, the transmitter running empty, a modem-status change and detection of an XOFF character. Each condition is gated by its enable bit. The highest-priority condition that is enabled is encoded in the identification byte, with an active-low pending flag in bit 0.

The FIFOs and the serializer sit outside the block. The receive FIFO fill level, the transmit-empty flags, a one-character-time tick from the baud logic and register-access strobes stand in for them. Software services the block in the usual way. It reads the identification byte, which acknowledges a transmit-empty or XOFF condition. It reads the line-status register to clear an error, reads the modem-status register to clear a modem change, and drains the receive holding register to clear receive data or timeout. A qualification input can hold the transmit-empty interrupt back until the transmit shift register has also finished.

Top module: `uiu_top`

## Requirements
- R1: After reset `iir` is 0x01 and `irq` is 0. `iir[0]` is 1 when nothing is pending and 0 when something is pending. `irq` always equals the inverse of `iir[0]`.
- R2: When an interrupt is pending, `iir` carries one of these type values in bits 5:1 (mask 0x3E), with bits 7:6 and bit 0 zero: line-status error 0x06, receive timeout 0x0C, receive data 0x04, transmit empty 0x02, modem change 0x00, XOFF 0x10.
- R3: When several enabled conditions are pending, the code shown follows this order, highest first: line status, timeout, receive data, transmit empty, modem change, XOFF.
- R4: `ier` bit 0 enables receive data and timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem change and bit 4 XOFF. A pending condition whose enable is 0 does not show in `iir` and does not raise `irq`.
- R5: The receive-data condition holds while `rxLevel` >= `rxTrigger`, and is absent at `rxTrigger`-1.
- R6: The timeout condition holds once TO_CHARS `charTick` pulses (default 4) have occurred while `rxLevel` is non-zero, with no `rxCharIn` or `rxRead` pulse in between. Either of those pulses, or an empty FIFO, clears it and restarts the count. It is absent after TO_CHARS-1 ticks.
- R7: The empty condition is `txFifoEmpty` when `scrTxQual` is 0, and `txFifoEmpty` and `txShiftEmpty` together when `scrTxQual` is 1. The transmit-empty interrupt is set when that condition, gated by `ier` bit 1, rises. It is dropped when the condition goes false.
- R8: An `iirRead` pulse while `iir` shows 0x02 clears the transmit-empty interrupt. It stays clear until the empty condition rises again.
- R9: A `lineErr` pulse latches the line-status condition. An `lsrRead` pulse clears it.
- R10: A `modemChange` pulse latches a condition that only an `msrRead` pulse clears; reading `iir` leaves it pending. An `xoffDetect` pulse latches a condition that an `iirRead` pulse clears while `iir` shows 0x10.
- R11: `iir` and `irq` show a change of pending state on the second rising clock edge after the input that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ier | input | 5 | Interrupt enables (see R4) |
| scrTxQual | input | 1 | Wait for the shift register before transmit-empty |
| rxLevel | input | LW | Receive FIFO fill level |
| rxTrigger | input | LW | Receive trigger level |
| rxCharIn | input | 1 | Pulse: a character entered the receive FIFO |
| rxRead | input | 1 | Pulse: receive holding register read |
| charTick | input | 1 | Pulse: one character time elapsed |
| txFifoEmpty | input | 1 | Transmit FIFO is empty |
| txShiftEmpty | input | 1 | Transmit shift register is empty |
| lineErr | input | 1 | Pulse: receive line error detected |
| lsrRead | input | 1 | Pulse: line-status register read |
| modemChange | input | 1 | Pulse: modem input changed |
| msrRead | input | 1 | Pulse: modem-status register read |
| xoffDetect | input | 1 | Pulse: XOFF character received |
| iirRead | input | 1 | Pulse: identification register read |
| iir | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that the strobe inputs are single-cycle pulses from a register-access decoder. They also assume that `rxLevel` never exceeds the FIFO depth and that `iirRead` only arrives while the byte being read is the registered `iir` value. The stimulus drives every pulse for exactly one clock, changes levels only between checks, and allows three clock edges of settling before each comparison. This way the expected code never depends on an in-flight update. Enable changes are ordered so that re-enabling transmit-empty happens only when a new interrupt is intended.

// File: rtl/uiu_pkg.sv
package uiu_pkg;
  localparam int NUM_SRC = 6;

  // priority index: 0 is highest
  localparam int SRC_LS = 0;
  localparam int SRC_TO = 1;
  localparam int SRC_RX = 2;
  localparam int SRC_TX = 3;
  localparam int SRC_MS = 4;
  localparam int SRC_XO = 5;

  localparam logic [7:0] IIR_NONE = 8'h01;
  localparam logic [7:0] IIR_LS   = 8'h06;
  localparam logic [7:0] IIR_TO   = 8'h0C;
  localparam logic [7:0] IIR_RX   = 8'h04;
  localparam logic [7:0] IIR_TX   = 8'h02;
  localparam logic [7:0] IIR_MS   = 8'h00;
  localparam logic [7:0] IIR_XO   = 8'h10;

  typedef struct packed {
    logic clrTx;
    logic clrXoff;
  } clrStrobes_t;

  function automatic logic [7:0] srcCode(input int idx);
    case (idx)
      SRC_LS:  return IIR_LS;
      SRC_TO:  return IIR_TO;
      SRC_RX:  return IIR_RX;
      SRC_TX:  return IIR_TX;
      SRC_MS:  return IIR_MS;
      default: return IIR_XO;
    endcase
  endfunction
endpackage

// File: rtl/uiu_srcpath.sv
module uiu_srcpath import uiu_pkg::*; #(
  parameter int LW = 7,
  parameter int TO_CHARS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        ier,
  input  logic              scrTxQual,
  input  logic [LW-1:0]     rxLevel,
  input  logic [LW-1:0]     rxTrigger,
  input  logic              rxCharIn,
  input  logic              rxRead,
  input  logic              charTick,
  input  logic              txFifoEmpty,
  input  logic              txShiftEmpty,
  input  logic              lineErr,
  input  logic              lsrRead,
  input  logic              modemChange,
  input  logic              msrRead,
  input  logic              xoffDetect,
  input  clrStrobes_t       clr,
  output logic [NUM_SRC-1:0] pend
);
  localparam int CW = $clog2(TO_CHARS + 1);
  localparam logic [CW-1:0] TO_LIMIT = CW'(TO_CHARS);

  logic [CW-1:0] toCnt;
  logic lsPend, msPend, xoPend, txPend, txArmQ;
  logic txCond, txArm, rxNonEmpty;

  assign rxNonEmpty = (rxLevel != '0);
  assign txCond = scrTxQual ? (txFifoEmpty & txShiftEmpty) : txFifoEmpty;
  assign txArm  = txCond & ier[1];

  // character-time counter for the receive timeout
  always_ff @(posedge clk) begin
    if (!rstN) toCnt <= '0;
    else if (!rxNonEmpty || rxCharIn || rxRead) toCnt <= '0;
    else if (charTick && toCnt != TO_LIMIT) toCnt <= toCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lsPend <= 1'b0;
      msPend <= 1'b0;
      xoPend <= 1'b0;
      txPend <= 1'b0;
      txArmQ <= 1'b0;
    end else begin
      if (lineErr) lsPend <= 1'b1;
      else if (lsrRead) lsPend <= 1'b0;
      if (modemChange) msPend <= 1'b1;
      else if (msrRead) msPend <= 1'b0;
      if (xoffDetect) xoPend <= 1'b1;
      else if (clr.clrXoff) xoPend <= 1'b0;
      txArmQ <= txArm;
      if (!txCond) txPend <= 1'b0;
      else if (txArm && !txArmQ) txPend <= 1'b1;
      else if (clr.clrTx) txPend <= 1'b0;
    end
  end

  always_comb begin
    pend = '0;
    pend[SRC_LS] = lsPend;
    pend[SRC_TO] = rxNonEmpty && (toCnt == TO_LIMIT);
    pend[SRC_RX] = rxNonEmpty && (rxLevel >= rxTrigger);
    pend[SRC_TX] = txPend;
    pend[SRC_MS] = msPend;
    pend[SRC_XO] = xoPend;
  end
endmodule

// File: rtl/uiu_ctrl.sv
module uiu_ctrl import uiu_pkg::*; (
  input  logic               clk,
  input  logic               rstN,
  input  logic [4:0]         ier,
  input  logic [NUM_SRC-1:0] pend,
  input  logic               iirRead,
  output clrStrobes_t        clr,
  output logic [7:0]         iir,
  output logic               irq
);
  logic [NUM_SRC-1:0] srcEn, active;
  logic [7:0] nextCode;
  logic [7:0] iirQ;
  logic irqQ;

  always_comb begin
    srcEn = '0;
    srcEn[SRC_LS] = ier[2];
    srcEn[SRC_TO] = ier[0];
    srcEn[SRC_RX] = ier[0];
    srcEn[SRC_TX] = ier[1];
    srcEn[SRC_MS] = ier[3];
    srcEn[SRC_XO] = ier[4];
  end

  assign active = pend & srcEn;

  // walk from lowest to highest priority; the last hit wins
  always_comb begin
    nextCode = IIR_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (active[i]) nextCode = srcCode(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iirQ <= IIR_NONE;
      irqQ <= 1'b0;
    end else begin
      iirQ <= nextCode;
      irqQ <= |active;
    end
  end

  assign clr.clrTx   = iirRead && (iirQ == IIR_TX);
  assign clr.clrXoff = iirRead && (iirQ == IIR_XO);
  assign iir = iirQ;
  assign irq = irqQ;
endmodule

// File: rtl/uiu_top.sv
module uiu_top import uiu_pkg::*; #(
  parameter int FIFO_DEPTH = 64,
  parameter int TO_CHARS = 4,
  localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [4:0]    ier,
  input  logic          scrTxQual,
  input  logic [LW-1:0] rxLevel,
  input  logic [LW-1:0] rxTrigger,
  input  logic          rxCharIn,
  input  logic          rxRead,
  input  logic          charTick,
  input  logic          txFifoEmpty,
  input  logic          txShiftEmpty,
  input  logic          lineErr,
  input  logic          lsrRead,
  input  logic          modemChange,
  input  logic          msrRead,
  input  logic          xoffDetect,
  input  logic          iirRead,
  output logic [7:0]    iir,
  output logic          irq
);
  clrStrobes_t clr;
  logic [NUM_SRC-1:0] pend;

  uiu_srcpath #(.LW(LW), .TO_CHARS(TO_CHARS)) u_src (
    .clk(clk), .rstN(rstN), .ier(ier), .scrTxQual(scrTxQual),
    .rxLevel(rxLevel), .rxTrigger(rxTrigger), .rxCharIn(rxCharIn),
    .rxRead(rxRead), .charTick(charTick), .txFifoEmpty(txFifoEmpty),
    .txShiftEmpty(txShiftEmpty), .lineErr(lineErr), .lsrRead(lsrRead),
    .modemChange(modemChange), .msrRead(msrRead), .xoffDetect(xoffDetect),
    .clr(clr), .pend(pend)
  );

  uiu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ier(ier), .pend(pend),
    .iirRead(iirRead), .clr(clr), .iir(iir), .irq(irq)
  );
endmodule

// File: rtl/uiu_chk.sv
module uiu_chk (
  input logic       clk,
  input logic       rstN,
  input logic [4:0] ier,
  input logic       lsrRead,
  input logic       lineErr,
  input logic [7:0] iir,
  input logic       irq
);
  // R1
  irq_matches_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq == !iir[0]);

  // R1
  idle_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    iir[0] |-> iir == 8'h01);

  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    iir == 8'h01 || iir == 8'h06 || iir == 8'h0C || iir == 8'h04 ||
    iir == 8'h02 || iir == 8'h00 || iir == 8'h10);

  // R4
  all_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ier) == 5'b0) |-> !irq);

  // R9
  ls_shows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineErr && ier[2] && $stable(ier)) |=> ##1 (!ier[2] || !$stable(ier) || $past(lsrRead) || iir == 8'h06));
endmodule

bind uiu_top uiu_chk u_chk (
  .clk(clk), .rstN(rstN), .ier(ier), .lsrRead(lsrRead),
  .lineErr(lineErr), .iir(iir), .irq(irq)
);

// File: tb/uiu_top_tb.sv
module uiu_top_tb;
  localparam int LW = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] ier = '0;
  logic scrTxQual = 1'b0;
  logic [LW-1:0] rxLevel = '0, rxTrigger = 7'd4;
  logic rxCharIn = 0, rxRead = 0, charTick = 0;
  logic txFifoEmpty = 0, txShiftEmpty = 0;
  logic lineErr = 0, lsrRead = 0, modemChange = 0, msrRead = 0;
  logic xoffDetect = 0, iirRead = 0;
  logic [7:0] iir;
  logic irq;

  always #10 clk = ~clk;

  uiu_top u_dut (
    .clk(clk), .rstN(rstN), .ier(ier), .scrTxQual(scrTxQual),
    .rxLevel(rxLevel), .rxTrigger(rxTrigger), .rxCharIn(rxCharIn),
    .rxRead(rxRead), .charTick(charTick), .txFifoEmpty(txFifoEmpty),
    .txShiftEmpty(txShiftEmpty), .lineErr(lineErr), .lsrRead(lsrRead),
    .modemChange(modemChange), .msrRead(msrRead), .xoffDetect(xoffDetect),
    .iirRead(iirRead), .iir(iir), .irq(irq)
  );

  typedef struct {
    string tag;
    logic [7:0] code;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  // monitor: compare on the falling edge, away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      nChecks++;
      if (iir !== e.code) begin
        nFails++;
        $display("FAIL %s: iir actual %02h expected %02h", e.tag, iir, e.code);
      end
      nChecks++;
      if (irq !== !e.code[0]) begin
        nFails++;
        $display("FAIL R1 (%s): irq actual %0b expected %0b", e.tag, irq, !e.code[0]);
      end
    end
  end

  task automatic expectIir(input string tag, input logic [7:0] code);
    repeat (3) @(posedge clk);
    #2;
    expQ.push_back('{tag, code});
    @(negedge clk);
    #1;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    expectIir("R1 reset", 8'h01);

    // receive data around the trigger level
    @(negedge clk) begin ier = 5'h1F; rxLevel = 7'd3; end
    expectIir("R5 below trigger", 8'h01);
    @(negedge clk) rxLevel = 7'd4;
    expectIir("R5 at trigger", 8'h04);
    pulse(lineErr);
    expectIir("R3 line status over rx", 8'h06);
    pulse(lsrRead);
    expectIir("R9 lsr read clears", 8'h04);
    @(negedge clk) rxLevel = 7'd0;
    expectIir("R5 empty", 8'h01);

    // receive timeout
    @(negedge clk) rxLevel = 7'd1;
    for (int i = 0; i < 3; i++) pulse(charTick);
    expectIir("R6 three ticks", 8'h01);
    pulse(charTick);
    expectIir("R6 timeout", 8'h0C);
    pulse(rxCharIn);
    expectIir("R6 new char restarts", 8'h01);
    for (int i = 0; i < 4; i++) pulse(charTick);
    expectIir("R6 timeout again", 8'h0C);
    pulse(rxRead);
    expectIir("R6 read clears", 8'h01);
    @(negedge clk) rxLevel = 7'd0;

    // transmit empty qualified by the shift register
    @(negedge clk) begin scrTxQual = 1'b1; txFifoEmpty = 1'b1; end
    expectIir("R7 shift still busy", 8'h01);
    @(negedge clk) txShiftEmpty = 1'b1;
    expectIir("R7 both empty", 8'h02);
    pulse(iirRead);
    expectIir("R8 iir read clears tx", 8'h01);
    @(negedge clk) txFifoEmpty = 1'b0;
    @(negedge clk) txFifoEmpty = 1'b1;
    expectIir("R8 rearmed", 8'h02);
    pulse(iirRead);
    expectIir("R8 cleared again", 8'h01);

    // modem change and XOFF
    pulse(modemChange);
    expectIir("R10 modem pending", 8'h00);
    pulse(iirRead);
    expectIir("R10 iir read keeps modem", 8'h00);
    pulse(msrRead);
    expectIir("R10 msr read clears", 8'h01);
    pulse(xoffDetect);
    expectIir("R10 xoff pending", 8'h10);
    pulse(modemChange);
    expectIir("R3 modem over xoff", 8'h00);
    pulse(msrRead);
    expectIir("R3 xoff remains", 8'h10);
    pulse(iirRead);
    expectIir("R10 iir read clears xoff", 8'h01);

    // masking of line status
    @(negedge clk) ier = 5'h1B;
    pulse(lineErr);
    expectIir("R4 line status masked", 8'h01);
    @(negedge clk) ier = 5'h1F;
    expectIir("R4 unmasked shows", 8'h06);
    pulse(lsrRead);
    expectIir("R9 cleared", 8'h01);

    // unqualified transmit empty
    @(negedge clk) txShiftEmpty = 1'b0;
    expectIir("R7 qualified drop", 8'h01);
    @(negedge clk) scrTxQual = 1'b0;
    expectIir("R7 fifo empty only", 8'h02);
    pulse(iirRead);
    expectIir("R8 cleared unqualified", 8'h01);

    // latency: visible on second edge, not first
    @(negedge clk) lineErr = 1'b1;
    @(negedge clk) lineErr = 1'b0;
    nChecks++;
    if (irq !== 1'b0) begin
      nFails++;
      $display("FAIL R11: irq after one edge actual %0b expected 0", irq);
    end
    @(negedge clk);
    nChecks++;
    if (iir !== 8'h06) begin
      nFails++;
      $display("FAIL R11: iir after two edges actual %02h expected 06", iir);
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule